// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block is the master side of the two-wire serial management link that a MAC uses to read and write the control registers of an Ethernet PHY. A host hands it one command at a time: a 5-bit PHY address, a 5-bit register number, 16 bits of write data and a read/write select. The block then produces the management clock and the data line from its system clock. It releases the data line whenever the PHY has to answer. When the transaction is finished it pulses `done`, with the read value and a no-response flag alongside.

Every transaction opens with a run of one bits on the driven data line. A write then shifts out a 32-bit frame. A read shifts out a 14-bit header, releases the line and samples the turnaround bit. If the PHY pulls that bit low, the block shifts in 16 data bits. If the line stays high, nothing answered and the read stops at once. Each completed frame is closed by one extra clock with the line released. The length of each clock phase is a number of system cycles set by a parameter. This allows the clock to be kept within the 20 ns minimum high and low time, which is a 25 MHz ceiling.

Top module: `mdio_frame_master`

## Requirements
- R1: Every transaction starts with PRE_LEN (default 32) consecutive management-clock cycles in which the data line is driven (`mdio_oe`=1) with value 1.
- R2: A read sends a 14-bit header after the preamble, MSB first: the start/opcode bits 0110, then `cmd_phy[4:0]`, then `cmd_reg[4:0]`.
- R3: A write sends a 32-bit frame after the preamble, MSB first: 0101, `cmd_phy[4:0]`, `cmd_reg[4:0]`, the turnaround pair 10, then `cmd_wdata[15:0]`.
- R4: After the read header the block releases the line and samples one turnaround bit. If that bit is 1, the transaction ends in that clock cycle with `rd_data`=0 and `no_resp`=1, and no further management clock follows.
- R5: When the turnaround bit is 0, the block samples 16 data bits MSB first, one per management clock. It returns them on `rd_data` with `no_resp`=0 when `done` pulses.
- R6: A completed read or write is followed by exactly one management clock with the line released. A read therefore has 46 driven and 18 released clock cycles, and a write has 64 driven and 1 released.
- R7: `mdio_out` and `mdio_oe` change only on a falling edge of `mdc` or when a command is accepted. They stay stable for the whole high phase.
- R8: Every high and low phase of `mdc` lasts exactly HALF_PERIOD system clock cycles.
- R9: `busy` rises in the cycle after a command is accepted and falls in the same cycle in which `done` pulses. `done` is high for exactly one cycle.
- R10: A command presented while `busy` is high is ignored: the frame in progress and its result are unchanged, and it produces no second `done`.
- R11: While idle, `mdc` is low and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_phy | input | 5 | Target PHY address |
| cmd_reg | input | 5 | Target register number |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with `done` |
| no_resp | output | 1 | Turnaround bit was not driven low, valid with `done` |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data value to drive on the line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_in | input | 1 | Sampled level of the data line |

## Verification
The bench builds the block with HALF_PERIOD=3 and the default 32-bit preamble. At 3 cycles per phase, a full 64- or 65-clock frame takes about 400 system cycles, so writes, answered reads, unanswered reads and commands arriving mid-frame all fit in one short run. Because 3 is odd and not a power of two, the phase counter's wrap point is tested rather than a natural rollover. The bench's PHY model answers per clock edge, so the turnaround abort path and the MSB-first data capture are both checked against edge counts and captured bit patterns.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PHY_W   = 5;
    localparam int REG_W   = 5;
    localparam int DATA_W  = 16;
    localparam int HDR_W   = 4 + PHY_W + REG_W;          // read header bits
    localparam int FRAME_W = HDR_W + 2 + DATA_W;         // full write frame bits
    localparam int CNT_W   = 6;                          // bit counter, covers preamble up to 64

    localparam logic [3:0] SOF_RD = 4'b0110;
    localparam logic [3:0] SOF_WR = 4'b0101;
    localparam logic [1:0] TA_WR  = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_RDAT,
        ST_TAIL
    } seq_st_e;

    typedef struct packed {
        seq_st_e            st;
        logic               hi;       // current phase is the high half
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;       // outgoing bits, MSB next
        logic [DATA_W-1:0]  rsh;      // incoming bits
        logic               rd;
        logic               mdc;
        logic               mdo;
        logic               oe;
        logic               done;
        logic               nores;
        logic [DATA_W-1:0]  rdata;
    } seq_q_t;

endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
    parameter int HALF_PERIOD = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int TW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [TW-1:0] LAST = TW'(HALF_PERIOD - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    input  logic [PHY_W-1:0]  cmd_phy,
    input  logic [REG_W-1:0]  cmd_reg,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              mdio_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              no_resp,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe
);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_LEN - 1);
    localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);

    seq_q_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.st == ST_IDLE) begin
            if (cmd_valid) begin
                d.st    = ST_PRE;
                d.cnt   = '0;
                d.hi    = 1'b0;
                d.mdc   = 1'b0;
                d.mdo   = 1'b1;
                d.oe    = 1'b1;
                d.rd    = cmd_read;
                d.nores = 1'b0;
                d.sh    = cmd_read ? {SOF_RD, cmd_phy, cmd_reg, {(FRAME_W-HDR_W){1'b0}}}
                                   : {SOF_WR, cmd_phy, cmd_reg, TA_WR, cmd_wdata};
            end
        end else if (tick) begin
            if (!q.hi) begin
                // end of low phase: rising edge, outputs already settled
                d.hi  = 1'b1;
                d.mdc = 1'b1;
            end else begin
                // end of high phase: sample, fall, set up next bit
                d.hi  = 1'b0;
                d.mdc = 1'b0;
                case (q.st)
                    ST_PRE: begin
                        if (q.cnt == PRE_LAST) begin
                            d.st  = ST_HDR;
                            d.cnt = '0;
                            d.mdo = q.sh[FRAME_W-1];
                            d.sh  = {q.sh[FRAME_W-2:0], 1'b0};
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                    ST_HDR: begin
                        if (q.cnt == (q.rd ? RD_LAST : WR_LAST)) begin
                            d.st  = q.rd ? ST_TA : ST_TAIL;
                            d.cnt = '0;
                            d.oe  = 1'b0;
                            d.mdo = 1'b0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                            d.mdo = q.sh[FRAME_W-1];
                            d.sh  = {q.sh[FRAME_W-2:0], 1'b0};
                        end
                    end
                    ST_TA: begin
                        if (mdio_in) begin
                            d.st    = ST_IDLE;
                            d.done  = 1'b1;
                            d.nores = 1'b1;
                            d.rdata = '0;
                        end else begin
                            d.st  = ST_RDAT;
                            d.cnt = '0;
                        end
                    end
                    ST_RDAT: begin
                        d.rsh = {q.rsh[DATA_W-2:0], mdio_in};
                        if (q.cnt == DAT_LAST) begin
                            d.st = ST_TAIL;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                    ST_TAIL: begin
                        d.st    = ST_IDLE;
                        d.done  = 1'b1;
                        d.nores = 1'b0;
                        d.rdata = q.rd ? q.rsh : '0;
                    end
                    default: d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;
    assign rd_data  = q.rdata;
    assign no_resp  = q.nores;
    assign mdc      = q.mdc;
    assign mdio_out = q.mdo;
    assign mdio_oe  = q.oe;

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
    parameter int HALF_PERIOD = 5,
    parameter int PRE_LEN     = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic        cmd_read,
    input  logic [4:0]  cmd_phy,
    input  logic [4:0]  cmd_reg,
    input  logic [15:0] cmd_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        no_resp,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    logic tick;

    mdio_phase_timer #(
        .HALF_PERIOD(HALF_PERIOD)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .tick (tick)
    );

    mdio_frame_seq #(
        .PRE_LEN(PRE_LEN)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cmd_valid(cmd_valid),
        .cmd_read (cmd_read),
        .cmd_phy  (cmd_phy),
        .cmd_reg  (cmd_reg),
        .cmd_wdata(cmd_wdata),
        .mdio_in  (mdio_in),
        .busy     (busy),
        .done     (done),
        .rd_data  (rd_data),
        .no_resp  (no_resp),
        .mdc      (mdc),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );

endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk #(
    parameter int HALF_PERIOD = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic [15:0] rd_data,
    input logic        no_resp,
    input logic        mdc,
    input logic        mdio_out,
    input logic        mdio_oe
);
    localparam int SW = $clog2(HALF_PERIOD + 1) + 1;
    localparam logic [SW-1:0] SAT = SW'(HALF_PERIOD);

    logic          mdc_prev_q;
    logic [SW-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_prev_q <= 1'b0;
            since_q    <= SAT;
        end else begin
            mdc_prev_q <= mdc;
            if (mdc != mdc_prev_q) begin
                since_q <= SW'(1);
            end else if (since_q < SAT) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    // R11: idle keeps the line released and the clock low
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));

    // R7: drive value and enable hold across the high phase
    a_r7_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

    // R7: enable only moves at a falling clock or at command accept
    a_r7_oe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe) |-> ($fell(mdc) || $rose(busy)));

    // R8: no clock phase shorter than HALF_PERIOD cycles
    a_r8_min_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc != mdc_prev_q) |-> (since_q >= SAT));

    // R9: done is a single-cycle pulse coinciding with busy falling
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_busy_ends_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R4: an unanswered read reports zero data
    a_r4_nores_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_resp) |-> (rd_data == 16'h0000));

endmodule

bind mdio_frame_master mdio_frame_master_chk #(
    .HALF_PERIOD(HALF_PERIOD)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .rd_data (rd_data),
    .no_resp (no_resp),
    .mdc     (mdc),
    .mdio_out(mdio_out),
    .mdio_oe (mdio_oe)
);

// File: tb/tb_mdio_frame_master.sv
module tb_mdio_frame_master;
    localparam int HALF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_read = 1'b0;
    logic [4:0]  cmd_phy = '0;
    logic [4:0]  cmd_reg = '0;
    logic [15:0] cmd_wdata = '0;
    logic        busy, done, no_resp, mdc, mdio_out, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_in = 1'b1;

    always #2 clk = ~clk;   // 250 MHz

    mdio_frame_master #(.HALF_PERIOD(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
        .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .no_resp(no_resp),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // PHY model and frame capture
    int          rises = 0, ndrv = 0, nrel = 0, hcnt = 0, hbad = 0;
    logic [63:0] cap = '0;
    logic        resp_ta = 1'b0;
    logic [15:0] resp_data = '0;

    always @(posedge mdc) begin
        if (mdio_oe) begin
            cap = {cap[62:0], mdio_out};
            ndrv++;
        end else begin
            nrel++;
        end
        if (rises == 46)                     mdio_in = resp_ta;
        else if (rises >= 47 && rises <= 62) mdio_in = resp_data[62 - rises];
        else                                 mdio_in = 1'b1;
        rises++;
    end

    always @(negedge clk) begin
        if (mdc) begin
            hcnt++;
        end else if (hcnt != 0) begin
            if (hcnt != HALF) hbad++;
            hcnt = 0;
        end
    end

    typedef struct {
        logic [63:0] frame;
        int          ndrv;
        int          nrel;
        logic [15:0] rdata;
        logic        nores;
    } exp_t;

    exp_t sbq[$];

    // monitor
    always begin
        @(negedge clk);
        if (done) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R10", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(rd_data == e.rdata, "R5", "read data", rd_data, e.rdata);
                chk(no_resp == e.nores, "R4", "no-response flag", no_resp, e.nores);
                chk(cap == e.frame, "R1/R2/R3", "driven bits", cap, e.frame);
                chk(ndrv == e.ndrv, "R1", "driven clock count", ndrv, e.ndrv);
                chk(nrel == e.nrel, "R6", "released clock count", nrel, e.nrel);
                chk(!busy, "R9", "busy at done", busy, 0);
                chk(!mdc && !mdio_oe, "R11", "line state at done", {mdc, mdio_oe}, 0);
                chk(hbad == 0, "R8", "bad high phases", hbad, 0);
            end
            @(negedge clk);
            chk(!done, "R9", "done width", done, 0);
        end
    end

    task automatic run_txn(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input bit ta, input logic [15:0] rsp,
                           input bit poke);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        resp_ta = ta; resp_data = rsp;
        rises = 0; ndrv = 0; nrel = 0; cap = '0; hbad = 0;
        if (rd) begin
            e.frame = {18'h0, 32'hFFFF_FFFF, 4'b0110, phy, rg};
            e.ndrv  = 46;
            e.nrel  = ta ? 1 : 18;
            e.rdata = ta ? 16'h0 : rsp;
            e.nores = ta;
        end else begin
            e.frame = {32'hFFFF_FFFF, 4'b0101, phy, rg, 2'b10, wd};
            e.ndrv  = 64;
            e.nrel  = 1;
            e.rdata = 16'h0;
            e.nores = 1'b0;
        end
        sbq.push_back(e);
        cmd_valid = 1'b1; cmd_read = rd; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy, "R9", "busy after accept", busy, 1);
        if (poke) begin
            repeat (40) @(negedge clk);
            cmd_valid = 1'b1; cmd_read = ~rd; cmd_phy = ~phy; cmd_reg = ~rg; cmd_wdata = ~wd;
            @(negedge clk);
            cmd_valid = 1'b0;
            chk(busy, "R10", "busy during ignored command", busy, 1);
        end
        while (sbq.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(!busy, "R10", "idle after transaction", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy, "R9", "reset busy", busy, 0);
        chk(!done, "R9", "reset done", done, 0);
        chk(!mdc, "R11", "reset mdc", mdc, 0);
        chk(!mdio_oe, "R11", "reset drive enable", mdio_oe, 0);

        run_txn(1'b0, 5'h11, 5'h04, 16'hA5C3, 1'b0, 16'h0000, 1'b0); // R3 write
        run_txn(1'b1, 5'h01, 5'h02, 16'h0000, 1'b0, 16'h1234, 1'b0); // R2 R5 read
        run_txn(1'b1, 5'h1F, 5'h1F, 16'h0000, 1'b1, 16'hBEEF, 1'b0); // R4 abort
        run_txn(1'b1, 5'h00, 5'h10, 16'h0000, 1'b0, 16'h8001, 1'b1); // R10 poke in read
        run_txn(1'b0, 5'h1E, 5'h00, 16'h0000, 1'b0, 16'h0000, 1'b1); // R10 poke in write
        run_txn(1'b1, 5'h0A, 5'h15, 16'h0000, 1'b0, 16'hFFFF, 1'b0); // R5 all ones

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule